// File: doc/BRIEF.md
# Handshaked Two-Bit Address Decoder

This block turns a two-bit address into a one-hot selection under a four-phase return-to-zero handshake, with no free-running decode. A controller places the address on `addr_msb`/`addr_lsb`, then raises `dec_req`. The block captures the address and drives exactly one of the four `hit` lines high. That line stays high while the request is held. When the controller lowers `dec_req`, the block lowers the selected line. This falling edge tells the controller that the operation has ended and that it may change the address again. While no operation is in progress the address pins have no effect.

Inside, each address bit goes to its own level-choice stage. The stage keeps an active-low pair of branch nodes, one for "bit is one" and one for "bit is zero", and reset presets both to 1. A join stage pairs the branches of the two bits into the four possible outcomes. A small controller sequences the work. Its state register has three states. BLOCKED is the reset state and waits for the request to be seen low. IDLE waits for a request. ACTIVE means a selection is being driven. There are four transitions: BLOCKED→IDLE when the request is low, IDLE→ACTIVE when the request is high (the capture), ACTIVE→IDLE when the request is low (the release), and any state→BLOCKED on reset.

Top module: `hs_addr_decode`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, all four `hit` bits are 0.
- R2: The selected line depends on {`addr_msb`,`addr_lsb`} as follows: 11 selects `hit[0]`, 10 selects `hit[1]`, 01 selects `hit[2]`, and 00 selects `hit[3]`.
- R3: If the block is idle and `dec_req` is sampled high at a rising clock edge, the address is captured at that edge and the selected `hit` bit is high immediately after that edge.
- R4: At no time is more than one `hit` bit high. While an operation is active, exactly one bit is high.
- R5: While `dec_req` is low and no operation is active, changes on the address pins leave all `hit` bits at 0.
- R6: While `dec_req` stays high, the selected `hit` bit stays unchanged for any number of cycles.
- R7: At the first rising edge where `dec_req` is sampled low during an operation, the selected `hit` bit returns to 0.
- R8: If `dec_req` is high when reset is released, no decode starts until `dec_req` has been sampled low and then high again.
- R9: A request raised on the cycle right after a release decodes the newly presented address with the latency of R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Asynchronous active-low reset to the BLOCKED state |
| dec_req | input | 1 | Decode request, four-phase return-to-zero |
| addr_msb | input | 1 | Upper address bit, held stable by the controller during an operation |
| addr_lsb | input | 1 | Lower address bit, held stable by the controller during an operation |
| hit | output | 4 | One-hot selection; its falling edge acknowledges the end of the operation |

## Verification
The assertions check the following on every cycle: no two selection lines are ever high together; a line rises only toward the address seen at the capture edge; the selection holds while the request is high and clears one cycle after the request is seen low; the output stays silent while the block is idle or blocked after reset; and the branch nodes return to their preset value whenever the controller is idle. Some behaviours appear only in the bench's scenarios. These are the exact latency from request to selection, the decode of every address value, the refusal of a request that was already high when reset was released, and the correct decode of back-to-back operations whose address changes between them.

// File: rtl/hsd_pkg.sv
package hsd_pkg;

    // Address width of one decode stage and the derived number of outcomes.
    localparam int ADDR_W = 2;
    localparam int SEL_W  = 1 << ADDR_W;
    // Each address bit owns a pair of active-low branch nodes.
    localparam int NODE_W = 2 * ADDR_W;

    typedef enum logic [1:0] {
        ST_BLOCKED = 2'd0,  // after reset, waiting for request low
        ST_IDLE    = 2'd1,  // waiting for a request
        ST_ACTIVE  = 2'd2   // a selection is driven
    } hsd_state_e;

endpackage

// File: rtl/hsd_ctrl.sv
module hsd_ctrl
    import hsd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    output logic       capture,
    output logic       release_op,
    output logic       drive,
    output hsd_state_e state
);

    hsd_state_e state_n;

    // Next-state logic.
    always_comb begin
        state_n = state;
        unique case (state)
            ST_BLOCKED: if (!req) state_n = ST_IDLE;
            ST_IDLE:    if (req)  state_n = ST_ACTIVE;
            ST_ACTIVE:  if (!req) state_n = ST_IDLE;
            default:              state_n = ST_BLOCKED;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_BLOCKED;
        else        state <= state_n;
    end

    // Outputs of the controller.
    always_comb begin
        capture    = 1'b0;
        release_op = 1'b0;
        drive      = 1'b0;
        unique case (state)
            ST_BLOCKED: ;
            ST_IDLE:    capture = req;
            ST_ACTIVE: begin
                drive      = 1'b1;
                release_op = !req;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/hsd_level_pick.sv
module hsd_level_pick (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       capture,
    input  logic       release_op,
    input  logic       addr_bit,
    // [1]: low when the bit was one, [0]: low when the bit was zero
    output logic [1:0] branch_n
);

    // The branch nodes are preset high and pulled low only for the chosen level.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            branch_n <= 2'b11;
        end else if (capture) begin
            branch_n <= {~addr_bit, addr_bit};
        end else if (release_op) begin
            branch_n <= 2'b11;
        end
    end

endmodule

// File: rtl/hsd_branch_join.sv
module hsd_branch_join
    import hsd_pkg::*;
(
    input  logic              drive,
    input  logic [NODE_W-1:0] node_n,
    output logic [SEL_W-1:0]  sel
);

    // Output j belongs to address value SEL_W-1-j; it needs the matching
    // branch of every bit.
    for (genvar j = 0; j < SEL_W; j++) begin : g_out
        localparam logic [ADDR_W-1:0] VAL = ADDR_W'(SEL_W - 1 - j);
        logic [ADDR_W-1:0] term;
        for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
            assign term[b] = ~node_n[2*b + int'(VAL[b])];
        end
        assign sel[j] = drive & (&term);
    end

endmodule

// File: rtl/hs_addr_decode.sv
module hs_addr_decode
    import hsd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dec_req,
    input  logic       addr_msb,
    input  logic       addr_lsb,
    output logic [3:0] hit
);

    logic              capture;
    logic              release_op;
    logic              drive;
    hsd_state_e        ctrl_state;
    logic [ADDR_W-1:0] addr_vec;
    logic [NODE_W-1:0] node_n;
    logic [SEL_W-1:0]  sel;

    assign addr_vec = {addr_msb, addr_lsb};

    hsd_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (dec_req),
        .capture    (capture),
        .release_op (release_op),
        .drive      (drive),
        .state      (ctrl_state)
    );

    // One level choice per address bit.
    for (genvar b = 0; b < ADDR_W; b++) begin : g_pick
        hsd_level_pick u_pick (
            .clk        (clk),
            .rst_n      (rst_n),
            .capture    (capture),
            .release_op (release_op),
            .addr_bit   (addr_vec[b]),
            .branch_n   (node_n[2*b +: 2])
        );
    end

    hsd_branch_join u_join (
        .drive  (drive),
        .node_n (node_n),
        .sel    (sel)
    );

    assign hit = sel;

endmodule

// File: rtl/hsd_checker.sv
module hsd_checker
    import hsd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dec_req,
    input  logic              addr_msb,
    input  logic              addr_lsb,
    input  logic [3:0]        hit,
    input  hsd_state_e        ctrl_state,
    input  logic [NODE_W-1:0] node_n
);

    // R4: never two selections at once
    p_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));

    // R4: exactly one selection while active
    p_active_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_state == ST_ACTIVE) |-> ($countones(hit) == 1));

    // R2, R3: a fresh selection matches the address at the capture edge
    p_map_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(hit) == 4'd0 && hit != 4'd0) |->
        (hit == (4'b0001 << (2'd3 - {$past(addr_msb), $past(addr_lsb)}))));

    // R6: selection is held while the request stays high
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != 4'd0 && dec_req) |=> $stable(hit));

    // R6: controller contract, address steady while a selection is up
    p_addr_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(hit) != 4'd0 && hit != 4'd0) |->
        $stable({addr_msb, addr_lsb}));

    // R7: release one cycle after the request is seen low
    p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != 4'd0 && !dec_req) |=> (hit == 4'd0));

    // R5: quiet while idle with no request
    p_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit == 4'd0 && !dec_req) |=> (hit == 4'd0));

    // R8: nothing is selected while blocked after reset
    p_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_state == ST_BLOCKED) |-> (hit == 4'd0));

    // R9: a new request never rises on top of a selection
    p_no_reentry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dec_req) |-> (hit == 4'd0));

    // R1: branch nodes sit at their preset value whenever idle
    p_nodes_preset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_state != ST_ACTIVE) |-> (&node_n));

endmodule

bind hs_addr_decode hsd_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dec_req    (dec_req),
    .addr_msb   (addr_msb),
    .addr_lsb   (addr_lsb),
    .hit        (hit),
    .ctrl_state (ctrl_state),
    .node_n     (node_n)
);

// File: tb/hs_addr_decode_bench.sv
module hs_addr_decode_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dec_req = 1'b0;
    logic       addr_msb = 1'b0;
    logic       addr_lsb = 1'b0;
    logic [3:0] hit;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    hs_addr_decode u_hs_addr_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .dec_req  (dec_req),
        .addr_msb (addr_msb),
        .addr_lsb (addr_lsb),
        .hit      (hit)
    );

    function automatic logic [3:0] exp_hit(input logic m, input logic l);
        case ({m, l})
            2'b11:   return 4'b0001;
            2'b10:   return 4'b0010;
            2'b01:   return 4'b0100;
            default: return 4'b1000;
        endcase
    endfunction

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: hit=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // One complete handshake; called right after a negedge with the block idle.
    task automatic run_op(input logic m, input logic l, input int hold, input bit same_cycle);
        addr_msb = m;
        addr_lsb = l;
        if (!same_cycle) @(negedge clk);
        dec_req = 1'b1;
        @(negedge clk);
        check("R3 R2 select after capture edge", hit, exp_hit(m, l));
        for (int k = 0; k < hold; k++) begin
            @(negedge clk);
            check("R6 selection held", hit, exp_hit(m, l));
        end
        dec_req = 1'b0;
        @(negedge clk);
        check("R7 selection released", hit, 4'd0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // R1: reset state
        #1;
        check("R1 during reset", hit, 4'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", hit, 4'd0);

        // R2: every address value, directed
        run_op(1'b1, 1'b1, 1, 1'b0);
        run_op(1'b1, 1'b0, 0, 1'b0);
        run_op(1'b0, 1'b1, 2, 1'b0);
        run_op(1'b0, 1'b0, 3, 1'b0);

        // R5: address toggling with request low
        for (int k = 0; k < 8; k++) begin
            addr_msb = 1'($urandom);
            addr_lsb = 1'($urandom);
            @(negedge clk);
            check("R5 idle address ignored", hit, 4'd0);
        end

        // R9: back-to-back requests with new addresses
        run_op(1'b0, 1'b0, 0, 1'b1);
        run_op(1'b1, 1'b1, 0, 1'b1);
        run_op(1'b0, 1'b1, 1, 1'b1);

        // R6: long hold
        run_op(1'b1, 1'b0, 20, 1'b0);

        // R8: request already high when reset is released
        rst_n = 1'b0;
        dec_req = 1'b1;
        addr_msb = 1'b0;
        addr_lsb = 1'b1;
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check("R8 stale request ignored", hit, 4'd0);
        end
        dec_req = 1'b0;
        @(negedge clk);
        check("R8 still quiet after drop", hit, 4'd0);
        run_op(1'b0, 1'b1, 1, 1'b0);

        // Random operations
        for (int n = 0; n < 150; n++) begin
            run_op(1'($urandom), 1'($urandom), int'($urandom_range(0, 4)),
                   bit'($urandom));
            for (int k = 0; k < int'($urandom_range(0, 2)); k++) begin
                addr_msb = 1'($urandom);
                addr_lsb = 1'($urandom);
                @(negedge clk);
                check("R5 idle gap quiet", hit, 4'd0);
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run hung, actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule